// File: doc/BRIEF.md
# Banked Static Word Memory with Run-Time Top-Bit Selection

This block is a synchronous word memory whose top address bit is taken, cycle by cycle, from one of two sources. A select input chooses either an ordinary high address line or a separate bank input. This lets one array be split on the fly: one half can hold program words and the other half can hold operands. With the select high, two operand spaces can also be steered into the upper and lower halves by the bank line.

Access is qualified by two chip enables of opposite polarity, an output enable and a write enable. All inputs are sampled on the rising clock edge, and the results appear on registered outputs one cycle later. A data-valid flag stands in for the drive of a three-state bus, and the data output reads zero whenever that flag is low. A standby flag reports when either enable is inactive. The default build has `LOW_AW` = 10. A build with `LOW_AW` = 12 and `DW` = 24 gives the 8K x 24 organisation.

Top module: `banked_sram`

## Requirements
- R1: The array holds 2^(LOW_AW+1) words of DW bits. The effective address is {top bit, addr_lo}, with the top bit as the most significant bit.
- R2: The part is selected only when ce_n is 0 and ce is 1. Otherwise, after the edge, standby is 1, dout_valid is 0, and no word is written even if we_n is 0.
- R3: When bank_mux is 1, bank_sel is the top address bit and addr_hi is ignored. When bank_mux is 0, addr_hi is the top bit and bank_sel is ignored.
- R4: A selected cycle with oe_n=0 and we_n=1 is a read. After that edge, dout holds the addressed word and dout_valid is 1.
- R5: A selected cycle with we_n=0 is a write at either oe_n level. The edge stores din at the effective address, and after that edge dout_valid is 0.
- R6: A selected cycle with oe_n=1 and we_n=1 leaves the outputs disabled. After that edge, dout_valid is 0 and standby is 0, and no word changes.
- R7: dout is all zeros whenever dout_valid is 0.
- R8: A read in the cycle right after a write to the same effective address returns the written data.
- R9: During and just after reset, dout_valid is 0, dout is 0 and standby is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers |
| ce_n | input | 1 | Active-low chip enable |
| ce | input | 1 | Active-high chip enable |
| oe_n | input | 1 | Active-low output enable |
| we_n | input | 1 | Active-low write enable |
| bank_mux | input | 1 | Top-bit source select: 1 = bank_sel, 0 = addr_hi |
| bank_sel | input | 1 | Bank line offered as top address bit |
| addr_hi | input | 1 | Plain high address line |
| addr_lo | input | LOW_AW | Low address bits |
| din | input | DW | Write data |
| dout | output | DW | Registered read data, zero when not driving |
| dout_valid | output | 1 | Registered flag standing for the bus drive |
| standby | output | 1 | Registered flag, high when either enable is inactive |

## Verification
The bench builds the block with LOW_AW = 3 and DW = 8. This gives a 16-word array, so every effective address can be written and read back through both top-bit paths.

With every word filled, each write through one path can be checked against reads through the other. The bench confirms that words alias only when the two paths produce the same top bit, and that the unused top-bit input never matters. Every enable combination is also applied to a full array, so a stray write in standby or disabled mode shows up when the array is read back.

// File: rtl/banked_sram_pkg.sv
package banked_sram_pkg;

    typedef enum logic [1:0] {
        MODE_STANDBY = 2'd0,
        MODE_OUT_OFF = 2'd1,
        MODE_READ    = 2'd2,
        MODE_WRITE   = 2'd3
    } access_mode_t;

endpackage

// File: rtl/bsram_mode_decode.sv
module bsram_mode_decode
    import banked_sram_pkg::*;
(
    input  logic         ce_n,
    input  logic         ce,
    input  logic         oe_n,
    input  logic         we_n,
    output access_mode_t mode
);
    logic selected;

    always_comb begin
        selected = !ce_n && ce;
        if (!selected)      mode = MODE_STANDBY;
        else if (!we_n)     mode = MODE_WRITE;   // write wins over output enable
        else if (!oe_n)     mode = MODE_READ;
        else                mode = MODE_OUT_OFF;
    end
endmodule

// File: rtl/bsram_addr_mux.sv
module bsram_addr_mux #(
    parameter int LOW_AW = 10
) (
    input  logic [LOW_AW-1:0] addr_lo,
    input  logic              addr_hi,
    input  logic              bank_sel,
    input  logic              bank_mux,
    output logic [LOW_AW:0]   eff_addr
);
    logic top_bit;

    always_comb begin
        top_bit  = bank_mux ? bank_sel : addr_hi;
        eff_addr = {top_bit, addr_lo};
    end
endmodule

// File: rtl/bsram_array.sv
module bsram_array #(
    parameter int AW = 11,
    parameter int DW = 24
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en) mem_q[addr] <= wdata;
    end

    always_comb rdata = mem_q[addr];
endmodule

// File: rtl/banked_sram.sv
module banked_sram
    import banked_sram_pkg::*;
#(
    parameter int LOW_AW = 10,
    parameter int DW     = 24
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              ce,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic              bank_mux,
    input  logic              bank_sel,
    input  logic              addr_hi,
    input  logic [LOW_AW-1:0] addr_lo,
    input  logic [DW-1:0]     din,
    output logic [DW-1:0]     dout,
    output logic              dout_valid,
    output logic              standby
);
    localparam int AW = LOW_AW + 1;

    typedef struct packed {
        logic [DW-1:0] data;
        logic          valid;
        logic          stby;
    } out_state_t;

    access_mode_t  mode;
    logic [AW-1:0] eff_addr;
    logic [DW-1:0] rdata;
    logic          wr_en;
    out_state_t    st_d, st_q;

    bsram_mode_decode u_decode (
        .ce_n (ce_n),
        .ce   (ce),
        .oe_n (oe_n),
        .we_n (we_n),
        .mode (mode)
    );

    bsram_addr_mux #(.LOW_AW(LOW_AW)) u_mux (
        .addr_lo  (addr_lo),
        .addr_hi  (addr_hi),
        .bank_sel (bank_sel),
        .bank_mux (bank_mux),
        .eff_addr (eff_addr)
    );

    always_comb wr_en = (mode == MODE_WRITE);

    bsram_array #(.AW(AW), .DW(DW)) u_array (
        .clk   (clk),
        .wr_en (wr_en),
        .addr  (eff_addr),
        .wdata (din),
        .rdata (rdata)
    );

    always_comb begin
        st_d       = '0;
        st_d.stby  = (mode == MODE_STANDBY);
        st_d.valid = (mode == MODE_READ);
        st_d.data  = (mode == MODE_READ) ? rdata : '0;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.stby <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign dout       = st_q.data;
    assign dout_valid = st_q.valid;
    assign standby    = st_q.stby;

    // R2: an inactive enable means standby and no drive next cycle
    a_r2_standby: assert property (@(posedge clk) disable iff (!rst_n)
        (ce_n || !ce) |=> (standby && !dout_valid));

    // R4: a selected read cycle drives the bus next cycle
    a_r4_read_drives: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ce && !oe_n && we_n) |=> (dout_valid && !standby));

    // R5: a write keeps the outputs released
    a_r5_write_hiz: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ce && !we_n) |=> !dout_valid);

    // R6: output-disabled cycle is neither driving nor standby
    a_r6_out_off: assert property (@(posedge clk) disable iff (!rst_n)
        (!ce_n && ce && oe_n && we_n) |=> (!dout_valid && !standby));

    // R7: released bus reads as zero
    a_r7_zero_when_off: assert property (@(posedge clk) disable iff (!rst_n)
        !dout_valid |-> (dout == '0));

    // R2: drive and standby never coexist
    a_r2_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(dout_valid && standby));
endmodule

// File: tb/banked_sram_tb.sv
`timescale 1ns/1ps
module banked_sram_tb;
    localparam int LOW_AW = 3;
    localparam int DW     = 8;
    localparam int WORDS  = 1 << (LOW_AW + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ce_n = 1'b1, ce = 1'b0, oe_n = 1'b1, we_n = 1'b1;
    logic bank_mux = 1'b0, bank_sel = 1'b0, addr_hi = 1'b0;
    logic [LOW_AW-1:0] addr_lo = '0;
    logic [DW-1:0] din = '0;
    logic [DW-1:0] dout;
    logic dout_valid, standby;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    logic [DW-1:0] model [WORDS];

    always #2 clk = ~clk;

    banked_sram #(.LOW_AW(LOW_AW), .DW(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .ce(ce), .oe_n(oe_n), .we_n(we_n),
        .bank_mux(bank_mux), .bank_sel(bank_sel), .addr_hi(addr_hi),
        .addr_lo(addr_lo), .din(din), .dout(dout), .dout_valid(dout_valid),
        .standby(standby)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic cyc(input logic cen, input logic cep, input logic oen, input logic wen,
                       input logic mx, input logic bk, input logic hi,
                       input logic [LOW_AW-1:0] lo, input logic [DW-1:0] d);
        ce_n = cen; ce = cep; oe_n = oen; we_n = wen;
        bank_mux = mx; bank_sel = bk; addr_hi = hi; addr_lo = lo; din = d;
        @(posedge clk);
        #1;
    endtask

    function automatic logic [DW-1:0] pat_a(input int a);
        return DW'((a * 37 + 5) & 8'hFF);
    endfunction

    function automatic logic [DW-1:0] pat_b(input int a);
        return DW'((a * 91 + 200) & 8'hFF);
    endfunction

    // read effective address a through chosen path and compare with model
    task automatic read_chk(input string req, input int a, input logic mx, input logic other);
        logic top;
        top = 1'(a >> LOW_AW);
        if (mx) cyc(0, 1, 0, 1, 1, top, other, LOW_AW'(a), '0);
        else    cyc(0, 1, 0, 1, 0, other, top, LOW_AW'(a), '0);
        check(req, {dout_valid, dout}, {1'b1, model[a]});
    endtask

    initial begin
        #400000;
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        // R9: reset state
        repeat (3) @(posedge clk);
        #1;
        check("R9 valid", dout_valid, 0);
        check("R9 dout", dout, 0);
        check("R9 standby", standby, 1);
        rst_n = 1'b1;

        // R1 R3: fill every word through the plain top bit, oe_n low (R5)
        for (int a = 0; a < WORDS; a++) begin
            cyc(0, 1, 0, 0, 0, 1'(~(a >> LOW_AW)), 1'(a >> LOW_AW), LOW_AW'(a), pat_a(a));
            model[a] = pat_a(a);
            check("R5 write no drive", {dout_valid, standby}, 2'b00);
        end
        // R3: read back through bank path, addr_hi opposite (ignored)
        for (int a = 0; a < WORDS; a++) read_chk("R3 bank path alias", a, 1, 1'(~(a >> LOW_AW)));

        // R3: overwrite upper half through bank path with oe_n high, addr_hi low
        for (int a = WORDS / 2; a < WORDS; a++) begin
            cyc(0, 1, 1, 0, 1, 1, 0, LOW_AW'(a), pat_b(a));
            model[a] = pat_b(a);
        end
        // R1 R3: lower half untouched, upper half new, via plain path
        for (int a = 0; a < WORDS; a++) read_chk("R1 R3 no alias", a, 0, 1'(~(a >> LOW_AW)));

        // R2: writes attempted in standby via each enable
        for (int a = 0; a < WORDS; a++) begin
            cyc(1, 1, 0, 0, 0, 0, 1'(a >> LOW_AW), LOW_AW'(a), 8'hEE);
            check("R2 standby ce_n", {standby, dout_valid, dout}, {2'b10, 8'h00});
            cyc(0, 0, 0, 0, 1, 1'(a >> LOW_AW), 0, LOW_AW'(a), 8'hDD);
            check("R2 standby ce", {standby, dout_valid, dout}, {2'b10, 8'h00});
        end
        // R6: output-disabled cycles
        for (int a = 0; a < WORDS; a++) begin
            cyc(0, 1, 1, 1, 0, 0, 1'(a >> LOW_AW), LOW_AW'(a), 8'hCC);
            check("R6 out off", {standby, dout_valid, dout}, {2'b00, 8'h00});
            check("R7 zero", dout, 0);
        end
        for (int a = 0; a < WORDS; a++) read_chk("R2 R6 array unchanged", a, 0, 0);

        // R8: write then immediately read each address, alternating paths
        for (int a = 0; a < WORDS; a++) begin
            logic top;
            top = 1'(a >> LOW_AW);
            cyc(0, 1, 0, 0, 1, top, ~top, LOW_AW'(a), DW'(a ^ 8'h5A));
            model[a] = DW'(a ^ 8'h5A);
            cyc(0, 1, 0, 1, 0, ~top, top, LOW_AW'(a), '0);
            check("R8 read after write", {dout_valid, dout}, {1'b1, model[a]});
            check("R4 standby low on read", standby, 0);
        end

        // R9: reset mid-run clears outputs
        cyc(0, 1, 0, 1, 0, 0, 0, 0, 0);
        rst_n = 1'b0;
        cyc(0, 1, 0, 1, 0, 0, 0, 0, 0);
        check("R9 reset again", {standby, dout_valid, dout}, {2'b10, 8'h00});
        rst_n = 1'b1;

        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule